// File: doc/BRIEF.md
# Configurable Synchronous Burst Flash Read Engine

This block is the memory side of a 16-bit flash read port. A 16-bit configuration register decides whether reads are asynchronous or clocked bursts. In asynchronous mode the addressed word appears on the data output without waiting for a clock, and the ready line stays active while the chip is enabled. In burst mode a start address is captured on a clock edge with enable and address-valid both low. After a programmable count of clock edges the engine puts out one word per clock, and it signals each valid word on a ready line.

The register fields are decoded live. They set the initial latency, the ready polarity, whether ready leads the data by a clock, the burst length (continuous, 8, 16 or 32 words), wrap inside an aligned block, and an optional one-clock pause when a linear burst steps onto a 128-word boundary. An illegal latency or length code falls back to the power-up choice and sets a sticky error flag. The register is loaded through a plain write port and can be read back.

Top module: `burst_flash_reader`

## Requirements
- R1: After reset the register reads 16'hEFC8: asynchronous mode, boundary pause on, latency code 101, ready active high, ready aligned with data, wrap on, continuous length. The error flag is 0.
- R2: With bit 15 at 1 and enable low, rdata equals the word at addr without any clock, and ready is active. The word at address a is (a*40503 + 4660) mod 65536.
- R3: With bit 15 at 0, an edge that sees enable and address-valid both low captures addr. The first word is shown after edge N counted from that edge, where N is 5, 6 or 7 for latency codes 011, 100 and 101 in bits 13:11.
- R4: Bit 10 sets the ready level: 1 means active high and 0 means active low. While enable is high, ready is at its inactive level.
- R5: With bit 8 at 0, ready goes active one clock before each word it announces. With bit 8 at 1, or with bits 13:11 at 000, ready is active in the same clock as the word.
- R6: Bits 2:0 set the length: 000 continuous, 010 gives 8 words, 011 gives 16 and 100 gives 32. A fixed burst drops ready after its last word and goes idle.
- R7: With bit 3 at 1 and a fixed length, the address counts up modulo the length inside the block aligned to that length.
- R8: In continuous mode, or with bit 3 at 0, the address counts up by one per word and wraps only at the top of the array.
- R9: With bit 14 at 1, a linear step onto an address that is a multiple of 128 inserts one clock in which ready is inactive and the previous word is held. With bit 14 at 0 there is no pause.
- R10: Writing a latency code other than 011, 100 or 101, or a length code other than 000, 010, 011 or 100, sets the error flag until reset. The engine then uses latency 101 or continuous length in its place.
- R11: Enable going high ends any burst or latency count at once, and the engine goes idle.
- R12: A write strobe loads cfg_wdata into the register on the clock edge, and cfg_rdata shows the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write value |
| cfg_rdata | output | 16 | Current register value |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| addr | input | AW | Word address |
| rdata | output | DW | Read data |
| rdy | output | 1 | Ready, level set by the register |
| cfg_err | output | 1 | Sticky flag for an illegal code |

## Verification
The first burst word is due exactly N edges after the capture edge, and each later word one edge after the one before it. A boundary pause delays the next word by one edge. In early mode ready is due one clock before the word it announces, while enable high and asynchronous data take effect with no clock at all. The bench keeps an expected entry for every clock after a capture edge in a queue, built when the capture happens. It pops one entry per rising edge and compares two time units after that edge. Early ready is checked against the head of the queue.

// File: rtl/burst_flash_reader.sv
module burst_flash_reader #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int BND = 7,
  parameter int LW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  output logic          rdy,
  output logic          cfg_err
);
  localparam logic [15:0] CFG_RST = 16'hEFC8;
  localparam logic [1:0]  S_IDLE = 2'd0, S_LAT = 2'd1, S_RUN = 2'd2;

  logic [15:0]   cfg_q;
  logic [1:0]    st;
  logic [2:0]    lat_cnt;
  logic [AW-1:0] ptr;
  logic [DW-1:0] data_q;
  logic          vld_q, stall_q, err_q;
  logic [LW-1:0] done_q;

  function automatic logic lat_legal(input logic [2:0] c);
    return (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic len_legal(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 + 32'd4660;
    return DW'(t);
  endfunction

  logic          async_md, bc_en, pol_hi, early_md, fixed, wrap_md;
  logic [2:0]    lat_code, first_edge;
  logic [LW-1:0] blen;
  logic [AW-1:0] wmask, inc, nxt;
  logic          last, hold, latch, load_next, act;

  assign async_md   = cfg_q[15];
  assign bc_en      = cfg_q[14];
  assign lat_code   = cfg_q[13:11];
  assign pol_hi     = cfg_q[10];
  assign first_edge = lat_legal(lat_code) ? lat_code + 3'd2 : 3'd7;
  assign early_md   = !cfg_q[8] && (lat_code != 3'd0);

  always_comb begin
    case (cfg_q[2:0])
      3'd2:    blen = LW'(8);
      3'd3:    blen = LW'(16);
      3'd4:    blen = LW'(32);
      default: blen = '0;
    endcase
  end

  assign fixed   = blen != '0;
  assign wrap_md = cfg_q[3] && fixed;
  assign wmask   = AW'(blen) - AW'(1);
  assign inc     = ptr + AW'(1);
  assign nxt     = wrap_md ? ((ptr & ~wmask) | (inc & wmask)) : inc;
  assign last    = fixed && (done_q == blen);
  assign hold    = !wrap_md && bc_en && (nxt[BND-1:0] == '0) && !stall_q && !last;
  assign latch   = !ce_n && !adv_n && !async_md;

  assign load_next = (st == S_LAT && lat_cnt == 3'd1) ||
                     (st == S_RUN && !last && !hold);
  assign act = ce_n ? 1'b0 : (async_md ? 1'b1 : (early_md ? load_next : vld_q));

  assign rdy       = pol_hi ? act : !act;
  assign rdata     = async_md ? word_at(addr) : data_q;
  assign cfg_rdata = cfg_q;
  assign cfg_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      err_q   <= 1'b0;
      st      <= S_IDLE;
      lat_cnt <= '0;
      ptr     <= '0;
      data_q  <= '0;
      vld_q   <= 1'b0;
      stall_q <= 1'b0;
      done_q  <= '0;
    end else begin
      if (cfg_we) begin
        cfg_q <= cfg_wdata;
        if (!lat_legal(cfg_wdata[13:11]) || !len_legal(cfg_wdata[2:0]))
          err_q <= 1'b1;
      end
      if (ce_n) begin
        st      <= S_IDLE;
        vld_q   <= 1'b0;
        stall_q <= 1'b0;
      end else if (latch) begin
        st      <= S_LAT;
        ptr     <= addr;
        lat_cnt <= first_edge;
        vld_q   <= 1'b0;
        stall_q <= 1'b0;
        done_q  <= '0;
      end else begin
        case (st)
          S_LAT: begin
            if (lat_cnt == 3'd1) begin
              data_q <= word_at(ptr);
              vld_q  <= 1'b1;
              done_q <= LW'(1);
              st     <= S_RUN;
            end else begin
              lat_cnt <= lat_cnt - 3'd1;
            end
          end
          S_RUN: begin
            if (last) begin
              st    <= S_IDLE;
              vld_q <= 1'b0;
            end else if (hold) begin
              stall_q <= 1'b1;
              vld_q   <= 1'b0;
            end else begin
              ptr     <= nxt;
              data_q  <= word_at(nxt);
              vld_q   <= 1'b1;
              stall_q <= 1'b0;
              if (fixed) done_q <= done_q + LW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module burst_flash_reader_chk #(
  parameter int DW = 16,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          err,
  input logic          stall,
  input logic          vld,
  input logic [1:0]    st,
  input logic [DW-1:0] data,
  input logic          fixed,
  input logic [LW-1:0] done,
  input logic [LW-1:0] blen
);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ce_n |=> (st == 2'd0 && !vld));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |-> $stable(data));
  // R9
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({vld, stall}));
  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) fixed |-> (done <= blen));
endmodule

bind burst_flash_reader burst_flash_reader_chk #(.DW(DW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .err(err_q), .stall(stall_q),
  .vld(vld_q), .st(st), .data(data_q), .fixed(fixed), .done(done_q), .blen(blen)
);

// File: tb/burst_flash_reader_tb.sv
module burst_flash_reader_tb_top;
  localparam int PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic          rst_n, cfg_we, ce_n, adv_n, rdy, cfg_err;
  logic [15:0]   cfg_wdata, cfg_rdata, rdata;
  logic [AW-1:0] addr;

  burst_flash_reader #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .rdata(rdata), .rdy(rdy), .cfg_err(cfg_err)
  );

  typedef struct packed { logic v; logic c; logic [15:0] d; } ent_t;
  ent_t        q[$];
  ent_t        cur;
  logic [15:0] mcfg;
  logic        merr;
  int          checks = 0, errors = 0;
  string       tag = "R1";
  bit          live = 0;

  function automatic logic [15:0] wd(input int a);
    return 16'((a * 40503 + 4660) % 65536);
  endfunction

  function automatic logic [15:0] mk(input bit md, input bit bc, input int lat, input bit pol,
                                     input bit rw, input bit wr, input int len);
    return {md, bc, 3'(lat), pol, 1'b1, rw, 2'b11, 2'b00, wr, 3'(len)};
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic build(input int a);
    int code, n, len, cnt, ai;
    bit wr;
    logic [15:0] prev;
    code = int'(mcfg[13:11]);
    n = (code >= 3 && code <= 5) ? code + 2 : 7;
    q.delete();
    for (int k = 1; k < n; k++) q.push_back('{1'b0, 1'b0, 16'h0});
    case (int'(mcfg[2:0]))
      2: len = 8;
      3: len = 16;
      4: len = 32;
      default: len = 0;
    endcase
    wr = mcfg[3] && (len != 0);
    cnt = (len != 0) ? len : 300;
    prev = 16'h0;
    for (int i = 0; i < cnt; i++) begin
      ai = wr ? ((a & ~(len - 1)) | ((a + i) & (len - 1))) : ((a + i) % 4096);
      if (i > 0 && !wr && mcfg[14] && (ai % 128) == 0) q.push_back('{1'b0, 1'b1, prev});
      q.push_back('{1'b1, 1'b1, wd(ai)});
      prev = wd(ai);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur  = '0;
      mcfg = 16'hEFC8;
      merr = 1'b0;
    end else begin
      if (ce_n) begin
        q.delete();
        cur = '0;
      end else if (!adv_n && !mcfg[15]) begin
        build(int'(addr));
        cur = '0;
      end else if (q.size() > 0) begin
        cur = q.pop_front();
      end else begin
        cur = '0;
      end
      if (cfg_we) begin
        if (!(cfg_wdata[13:11] inside {3'd3, 3'd4, 3'd5}) ||
            !(cfg_wdata[2:0] inside {3'd0, 3'd2, 3'd3, 3'd4}))
          merr = 1'b1;
        mcfg = cfg_wdata;
      end
    end
    #2;
    if (live && rst_n) begin
      logic act, early;
      chk("R12 readback", 32'(cfg_rdata), 32'(mcfg));
      chk("R10 error flag", 32'(cfg_err), 32'(merr));
      if (mcfg[15]) begin
        act = !ce_n;
        if (!ce_n) chk({tag, " async data"}, 32'(rdata), 32'(wd(int'(addr))));
      end else begin
        early = !mcfg[8] && (mcfg[13:11] != 3'd0);
        act = ce_n ? 1'b0 : (early ? (q.size() > 0 && q[0].v) : cur.v);
        if (cur.c) chk({tag, " burst data"}, 32'(rdata), 32'(cur.d));
      end
      chk({tag, " R4 ready level"}, 32'(rdy), 32'(mcfg[10] ? act : !act));
    end
  end

  task automatic wcfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic burst(input int a, input int cyc);
    @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; addr = AW'(a);
    @(negedge clk); adv_n = 1'b1;
    repeat (cyc) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; ce_n = 1'b1; adv_n = 1'b1; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk("R1 reset register", 32'(cfg_rdata), 32'h0000EFC8);
    chk("R1 reset error flag", 32'(cfg_err), 32'h0);
    chk("R1 R4 reset ready", 32'(rdy), 32'h0);
    live = 1;

    tag = "R2";
    @(negedge clk); ce_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      addr = AW'(i * 677 + 3);
      @(negedge clk);
    end
    ce_n = 1'b1;
    @(negedge clk);

    tag = "R12 R3 R7 R6";
    wcfg(mk(0, 1, 3, 1, 1, 1, 2));
    burst(12'h105, 20);

    tag = "R3 R8 R9 R6";
    wcfg(mk(0, 1, 4, 1, 1, 0, 3));
    burst(12'h07A, 30);

    tag = "R4 R5 R7";
    wcfg(mk(0, 1, 5, 0, 0, 1, 4));
    burst(12'h3E5, 45);

    tag = "R8 R9 off";
    wcfg(mk(0, 0, 3, 1, 1, 0, 0));
    burst(12'h0FC, 20);

    tag = "R9 R5 early";
    wcfg(mk(0, 1, 3, 1, 0, 0, 0));
    burst(12'h17D, 20);

    tag = "R11";
    burst(12'h200, 3);
    burst(12'h27E, 9);

    tag = "R10 R5 latency";
    wcfg(mk(0, 1, 0, 1, 0, 1, 2));
    burst(12'h010, 20);

    tag = "R10 R6 length";
    wcfg(mk(0, 1, 5, 1, 1, 1, 5));
    burst(12'h0F0, 25);

    tag = "R2 return";
    wcfg(mk(1, 1, 5, 0, 1, 1, 0));
    @(negedge clk); ce_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      addr = AW'(4095 - i * 901);
      @(negedge clk);
    end
    ce_n = 1'b1;
    repeat (3) @(negedge clk);

    live = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule